// File: doc/BRIEF.md
# Posted Write Buffer with Read-After-Write Ordering

This block sits on the slave side of an AXI-style port and drives a simple request/acknowledge memory port. Each incoming write is queued as a burst entry, with its address, length, beat size, burst kind and data beats. A write that the master marks bufferable and that targets a memory region is acknowledged as soon as its last data beat is held. Any other write is acknowledged only once its final beat has been accepted by memory. Queued entries drain to memory in arrival order, one beat per memory handshake.

Every read is compared against all queued entries using the full byte span of each burst. A read that touches any queued byte waits until every entry present when it arrived has drained, so it always returns the newest data. A read that touches no queued byte goes to memory ahead of the pending writes. A read flagged as peripheral gets no overlap test and always waits for all earlier writes. A single transaction ID is assumed. Only INCR and FIXED bursts are handled.

Top module: `posted_wr_buf`

## Requirements
- R1: A write with aw_bufable_i=1 and aw_periph_i=0 raises b_valid_o before any of its beats has been acknowledged by memory.
- R2: A write with aw_bufable_i=0, or with aw_periph_i=1, raises b_valid_o only after memory has acknowledged the last beat of that write.
- R3: A read whose byte span overlaps a queued write issues its first memory request only after all beats of the writes queued ahead of it have been acknowledged, and it returns the written data.
- R4: Byte span is [addr, addr+(len+1)*2^size-1] for INCR (aw/ar_incr_i=1) and [addr, addr+2^size-1] for FIXED (incr=0). Spans that only touch at an edge do not overlap.
- R5: A read whose span overlaps no queued write may reach memory before the queued write beats do.
- R6: A read with ar_periph_i=1 waits for all earlier queued writes to be acknowledged, whether or not the spans overlap.
- R7: Write beats reach memory in arrival order. The beat address is addr+k*2^size for INCR and addr for every beat of FIXED. mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold steady until mem_ack_i.
- R8: With 4 entries queued, aw_ready_o is low.
- R9: b_resp_o is 2'b00 (OKAY). Once raised, b_valid_o holds until b_ready_i. Once raised, r_valid_o holds with stable r_data_o and r_last_o until r_ready_i.
- R10: After reset, aw_ready_o and ar_ready_o are high, and b_valid_o, r_valid_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_o | output | 1 | Write address accepted |
| aw_addr_i | input | ADDR_W | Write start byte address |
| aw_len_i | input | LEN_W | Write beats minus one |
| aw_size_i | input | 3 | log2 of bytes per write beat |
| aw_incr_i | input | 1 | 1 = INCR, 0 = FIXED |
| aw_bufable_i | input | 1 | Write may be acknowledged early |
| aw_periph_i | input | 1 | Write targets a peripheral region |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data accepted |
| w_data_i | input | DATA_W | Write data beat |
| w_last_i | input | 1 | Final write beat |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Write response taken |
| b_resp_o | output | 2 | Write response code, always OKAY |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address accepted |
| ar_addr_i | input | ADDR_W | Read start byte address |
| ar_len_i | input | LEN_W | Read beats minus one |
| ar_size_i | input | 3 | log2 of bytes per read beat |
| ar_incr_i | input | 1 | 1 = INCR, 0 = FIXED |
| ar_periph_i | input | 1 | Read targets a peripheral region |
| r_valid_o | output | 1 | Read data valid |
| r_ready_i | input | 1 | Read data taken |
| r_data_o | output | DATA_W | Read data beat |
| r_last_o | output | 1 | Final read beat |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr_o | output | ADDR_W | Memory beat byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory beat done |
| mem_rdata_i | input | DATA_W | Memory read data, valid with ack |

## Verification
Reads and the write drain share one memory port. A cycle in which the port is idle can therefore see both a non-overlapping read that is ready to go and a queued write beat that is ready to drain. The bench sets up this conflict by holding the memory acknowledge off while a two-beat write sits at the head of the queue and a read is accepted behind it, and then releasing the memory. The verdict comes from the number of write beats memory has acknowledged when the first read beat is served: one for a read that does not overlap, which shows it won the idle cycle, and the full burst for an overlapping or peripheral read.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {MEM_IDLE, MEM_WR, MEM_RD} mem_st_e;
endpackage

// File: rtl/pwb_range.sv
module pwb_range #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        size_i,
  input  logic              incr_i,
  output logic [ADDR_W:0]   lo_o,
  output logic [ADDR_W:0]   hi_o
);
  localparam int RW = ADDR_W + 1;
  logic [RW-1:0] beats, span;

  always_comb begin
    beats = incr_i ? (RW'(len_i) + RW'(1)) : RW'(1);
    span  = beats << size_i;
    lo_o  = RW'(addr_i);
    hi_o  = lo_o + span - RW'(1);
  end
endmodule

// File: rtl/pwb_queue.sv
module pwb_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [LEN_W-1:0]  alloc_len_i,
  input  logic [2:0]        alloc_size_i,
  input  logic              alloc_incr_i,
  input  logic              alloc_posted_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_last_i,
  input  logic              pop_i,
  input  logic [ADDR_W:0]   qry_lo_i,
  input  logic [ADDR_W:0]   qry_hi_i,
  output logic              hit_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              head_rdy_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [LEN_W-1:0]  head_len_o,
  output logic [2:0]        head_size_o,
  output logic              head_incr_o,
  output logic              head_posted_o,
  input  logic [LEN_W-1:0]  head_beat_i,
  output logic [DATA_W-1:0] head_data_o
);
  localparam int BEATS = 2 ** LEN_W;

  logic [DEPTH-1:0]  valid_q, done_q, incr_q, posted_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LEN_W-1:0]  len_q  [DEPTH];
  logic [2:0]        size_q [DEPTH];
  logic [ADDR_W:0]   lo_q   [DEPTH];
  logic [ADDR_W:0]   hi_q   [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH][BEATS];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, fill_ptr_q;
  logic [LEN_W-1:0]  fill_beat_q;
  logic [CNT_W-1:0]  count_q;
  logic [ADDR_W:0]   new_lo, new_hi;
  logic [DEPTH-1:0]  hit_vec;

  pwb_range #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rng (
    .addr_i(alloc_addr_i), .len_i(alloc_len_i), .size_i(alloc_size_i),
    .incr_i(alloc_incr_i), .lo_o(new_lo), .hi_o(new_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= '0;
      done_q      <= '0;
      incr_q      <= '0;
      posted_q    <= '0;
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      fill_ptr_q  <= '0;
      fill_beat_q <= '0;
      count_q     <= '0;
    end else begin
      if (alloc_i) begin
        valid_q[wr_ptr_q]  <= 1'b1;
        done_q[wr_ptr_q]   <= 1'b0;
        incr_q[wr_ptr_q]   <= alloc_incr_i;
        posted_q[wr_ptr_q] <= alloc_posted_i;
        fill_ptr_q         <= wr_ptr_q;
        fill_beat_q        <= '0;
        wr_ptr_q           <= wr_ptr_q + PTR_W'(1);
      end
      if (fill_i) begin
        fill_beat_q <= fill_beat_q + LEN_W'(1);
        if (fill_last_i) done_q[fill_ptr_q] <= 1'b1;
      end
      if (pop_i) begin
        valid_q[rd_ptr_q] <= 1'b0;
        rd_ptr_q          <= rd_ptr_q + PTR_W'(1);
      end
      count_q <= count_q + CNT_W'(alloc_i) - CNT_W'(pop_i);
    end
  end

  // payload needs no reset: qualified by valid_q/done_q
  always_ff @(posedge clk_i) begin
    if (alloc_i) begin
      addr_q[wr_ptr_q] <= alloc_addr_i;
      len_q[wr_ptr_q]  <= alloc_len_i;
      size_q[wr_ptr_q] <= alloc_size_i;
      lo_q[wr_ptr_q]   <= new_lo;
      hi_q[wr_ptr_q]   <= new_hi;
    end
    if (fill_i) data_q[fill_ptr_q][fill_beat_q] <= fill_data_i;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = valid_q[i] && (lo_q[i] <= qry_hi_i) && (qry_lo_i <= hi_q[i]);
  end

  assign hit_o         = |hit_vec;
  assign count_o       = count_q;
  assign full_o        = (count_q == CNT_W'(DEPTH));
  assign head_rdy_o    = valid_q[rd_ptr_q] && done_q[rd_ptr_q];
  assign head_addr_o   = addr_q[rd_ptr_q];
  assign head_len_o    = len_q[rd_ptr_q];
  assign head_size_o   = size_q[rd_ptr_q];
  assign head_incr_o   = incr_q[rd_ptr_q];
  assign head_posted_o = posted_q[rd_ptr_q];
  assign head_data_o   = data_q[rd_ptr_q][head_beat_i];
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aw_valid_i,
  output logic              aw_ready_o,
  input  logic [ADDR_W-1:0] aw_addr_i,
  input  logic [LEN_W-1:0]  aw_len_i,
  input  logic [2:0]        aw_size_i,
  input  logic              aw_incr_i,
  input  logic              aw_bufable_i,
  input  logic              aw_periph_i,
  input  logic              w_valid_i,
  output logic              w_ready_o,
  input  logic [DATA_W-1:0] w_data_i,
  input  logic              w_last_i,
  output logic              b_valid_o,
  input  logic              b_ready_i,
  output logic [1:0]        b_resp_o,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  input  logic [ADDR_W-1:0] ar_addr_i,
  input  logic [LEN_W-1:0]  ar_len_i,
  input  logic [2:0]        ar_size_i,
  input  logic              ar_incr_i,
  input  logic              ar_periph_i,
  output logic              r_valid_o,
  input  logic              r_ready_i,
  output logic [DATA_W-1:0] r_data_o,
  output logic              r_last_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import pwb_pkg::*;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic              wr_fill_q, cur_posted_q, b_pend_q, nb_wait_q;
  logic              rd_act_q, r_valid_q, r_last_q;
  logic [CNT_W-1:0]  rd_wait_q;
  logic [LEN_W-1:0]  rd_beat_q, dr_beat_q, ar_len_q;
  logic [ADDR_W-1:0] ar_addr_q, m_addr_q;
  logic [2:0]        ar_size_q;
  logic              ar_incr_q;
  logic [DATA_W-1:0] r_data_q, m_data_q;
  mem_st_e           mst_q;

  logic              q_hit, q_full, head_rdy, head_incr, head_posted;
  logic [CNT_W-1:0]  q_count;
  logic [ADDR_W-1:0] head_addr;
  logic [LEN_W-1:0]  head_len;
  logic [2:0]        head_size;
  logic [DATA_W-1:0] head_data;
  logic [ADDR_W:0]   ar_lo, ar_hi;
  logic              aw_hs, w_hs, ar_hs, r_hs, wr_ack, rd_ack, retire, rd_go;

  function automatic logic [ADDR_W-1:0] beat_off(logic [LEN_W-1:0] b, logic [2:0] s, logic inc);
    return inc ? (ADDR_W'(b) << s) : '0;
  endfunction

  assign aw_ready_o = !wr_fill_q && !b_pend_q && !nb_wait_q && !q_full;
  assign w_ready_o  = wr_fill_q;
  assign ar_ready_o = !rd_act_q;
  assign aw_hs      = aw_valid_i && aw_ready_o;
  assign w_hs       = w_valid_i && wr_fill_q;
  assign ar_hs      = ar_valid_i && ar_ready_o;
  assign r_hs       = r_valid_q && r_ready_i;
  assign wr_ack     = (mst_q == MEM_WR) && mem_ack_i;
  assign rd_ack     = (mst_q == MEM_RD) && mem_ack_i;
  assign retire     = wr_ack && (dr_beat_q == head_len);
  assign rd_go      = rd_act_q && (rd_wait_q == '0) && !r_valid_q;

  pwb_range #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ar_rng (
    .addr_i(ar_addr_i), .len_i(ar_len_i), .size_i(ar_size_i),
    .incr_i(ar_incr_i), .lo_o(ar_lo), .hi_o(ar_hi)
  );

  pwb_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_q (
    .clk_i, .rst_ni,
    .alloc_i(aw_hs), .alloc_addr_i(aw_addr_i), .alloc_len_i(aw_len_i),
    .alloc_size_i(aw_size_i), .alloc_incr_i(aw_incr_i),
    .alloc_posted_i(aw_bufable_i && !aw_periph_i),
    .fill_i(w_hs), .fill_data_i(w_data_i), .fill_last_i(w_last_i),
    .pop_i(retire), .qry_lo_i(ar_lo), .qry_hi_i(ar_hi), .hit_o(q_hit),
    .count_o(q_count), .full_o(q_full), .head_rdy_o(head_rdy),
    .head_addr_o(head_addr), .head_len_o(head_len), .head_size_o(head_size),
    .head_incr_o(head_incr), .head_posted_o(head_posted),
    .head_beat_i(dr_beat_q), .head_data_o(head_data)
  );

  // write intake and response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_fill_q    <= 1'b0;
      cur_posted_q <= 1'b0;
      b_pend_q     <= 1'b0;
      nb_wait_q    <= 1'b0;
    end else begin
      if (aw_hs) begin
        wr_fill_q    <= 1'b1;
        cur_posted_q <= aw_bufable_i && !aw_periph_i;
      end
      if (b_valid_o && b_ready_i) b_pend_q <= 1'b0;
      if (w_hs && w_last_i) begin
        wr_fill_q <= 1'b0;
        if (cur_posted_q) b_pend_q  <= 1'b1;
        else              nb_wait_q <= 1'b1;
      end
      if (retire && !head_posted) begin
        b_pend_q  <= 1'b1;
        nb_wait_q <= 1'b0;
      end
    end
  end

  // read ordering and data return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q  <= 1'b0;
      rd_wait_q <= '0;
      rd_beat_q <= '0;
      ar_addr_q <= '0;
      ar_len_q  <= '0;
      ar_size_q <= '0;
      ar_incr_q <= 1'b0;
      r_valid_q <= 1'b0;
      r_last_q  <= 1'b0;
      r_data_q  <= '0;
    end else begin
      if (ar_hs) begin
        rd_act_q  <= 1'b1;
        rd_beat_q <= '0;
        ar_addr_q <= ar_addr_i;
        ar_len_q  <= ar_len_i;
        ar_size_q <= ar_size_i;
        ar_incr_q <= ar_incr_i;
        // entries present now must drain first; exclude one retiring this cycle
        rd_wait_q <= (q_hit || ar_periph_i) ? (q_count - CNT_W'(retire)) : '0;
      end else if (retire && rd_wait_q != '0) begin
        rd_wait_q <= rd_wait_q - CNT_W'(1);
      end
      if (rd_ack) begin
        r_valid_q <= 1'b1;
        r_data_q  <= mem_rdata_i;
        r_last_q  <= (rd_beat_q == ar_len_q);
      end
      if (r_hs) begin
        r_valid_q <= 1'b0;
        if (r_last_q) rd_act_q <= 1'b0;
        else          rd_beat_q <= rd_beat_q + LEN_W'(1);
      end
    end
  end

  // memory port: read bypass wins an idle cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_q     <= MEM_IDLE;
      m_addr_q  <= '0;
      m_data_q  <= '0;
      dr_beat_q <= '0;
    end else begin
      unique case (mst_q)
        MEM_IDLE: begin
          if (rd_go) begin
            mst_q    <= MEM_RD;
            m_addr_q <= ar_addr_q + beat_off(rd_beat_q, ar_size_q, ar_incr_q);
          end else if (head_rdy) begin
            mst_q    <= MEM_WR;
            m_addr_q <= head_addr + beat_off(dr_beat_q, head_size, head_incr);
            m_data_q <= head_data;
          end
        end
        MEM_WR: if (mem_ack_i) begin
          mst_q     <= MEM_IDLE;
          dr_beat_q <= retire ? '0 : dr_beat_q + LEN_W'(1);
        end
        MEM_RD: if (mem_ack_i) mst_q <= MEM_IDLE;
        default: mst_q <= MEM_IDLE;
      endcase
    end
  end

  assign b_valid_o   = b_pend_q;
  assign b_resp_o    = 2'b00;
  assign r_valid_o   = r_valid_q;
  assign r_data_o    = r_data_q;
  assign r_last_o    = r_last_q;
  assign mem_req_o   = (mst_q != MEM_IDLE);
  assign mem_we_o    = (mst_q == MEM_WR);
  assign mem_addr_o  = m_addr_q;
  assign mem_wdata_o = m_data_q;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              aw_valid_i,
  input logic              aw_ready_o,
  input logic              aw_bufable_i,
  input logic              aw_periph_i,
  input logic              b_valid_o,
  input logic              b_ready_i,
  input logic              r_valid_o,
  input logic              r_ready_i,
  input logic [DATA_W-1:0] r_data_o,
  input logic              r_last_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  logic nb_open_q, ack_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nb_open_q  <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      if (b_valid_o && b_ready_i) nb_open_q <= 1'b0;
      if (nb_open_q && mem_req_o && mem_we_o && mem_ack_i) ack_seen_q <= 1'b1;
      if (aw_valid_i && aw_ready_o && !(aw_bufable_i && !aw_periph_i)) begin
        nb_open_q  <= 1'b1;
        ack_seen_q <= 1'b0;
      end
    end
  end

  p_nb_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nb_open_q && $rose(b_valid_o)) |-> ack_seen_q);

  p_b_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_valid_o && !b_ready_i) |=> b_valid_o);

  p_r_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && !r_ready_i) |=> (r_valid_o && $stable(r_data_o) && $stable(r_last_o)));

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)));
endmodule

bind posted_wr_buf pwb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .aw_valid_i(aw_valid_i), .aw_ready_o(aw_ready_o),
  .aw_bufable_i(aw_bufable_i), .aw_periph_i(aw_periph_i),
  .b_valid_o(b_valid_o), .b_ready_i(b_ready_i),
  .r_valid_o(r_valid_o), .r_ready_i(r_ready_i), .r_data_o(r_data_o), .r_last_o(r_last_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
);

// File: tb/tb_posted_wr_buf.sv
`timescale 1ns/1ps
module tb_posted_wr_buf;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        aw_valid_i = 0, aw_incr_i = 0, aw_bufable_i = 0, aw_periph_i = 0;
  logic [15:0] aw_addr_i = '0, ar_addr_i = '0;
  logic [1:0]  aw_len_i = '0, ar_len_i = '0;
  logic [2:0]  aw_size_i = '0, ar_size_i = '0;
  logic        w_valid_i = 0, w_last_i = 0, b_ready_i = 1, ar_valid_i = 0;
  logic        ar_incr_i = 0, ar_periph_i = 0, r_ready_i = 1;
  logic [31:0] w_data_i = '0;
  logic        aw_ready_o, w_ready_o, b_valid_o, ar_ready_o, r_valid_o, r_last_o;
  logic [1:0]  b_resp_o;
  logic [31:0] r_data_o, mem_wdata_o;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic        mem_ack_i = 0;
  logic [31:0] mem_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  posted_wr_buf dut (.*);

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit frozen = 1'b0;
  logic [31:0] mem_m [int];
  int wr_cnt = 0, rd_cnt = 0, r_n = 0, b_n = 0, b_wcnt = 0;
  int wr_log [512];
  int rd_wlog [512];
  logic [31:0] rbuf [512];

  // memory model: ack one cycle after request
  always @(negedge clk_i) begin
    if (mem_ack_i) mem_ack_i <= 1'b0;
    else if (mem_req_o && !frozen) begin
      mem_ack_i <= 1'b1;
      if (mem_we_o) begin
        mem_m[int'(mem_addr_o)] = mem_wdata_o;
        wr_log[wr_cnt] = int'(mem_addr_o);
        wr_cnt++;
      end else begin
        mem_rdata_i <= mem_m.exists(int'(mem_addr_o)) ? mem_m[int'(mem_addr_o)] : 32'h0;
        rd_wlog[rd_cnt] = wr_cnt;
        rd_cnt++;
      end
    end
  end

  always @(negedge clk_i) begin
    if (r_valid_o && r_ready_i) begin rbuf[r_n] = r_data_o; r_n++; end
    if (b_valid_o && b_ready_i) begin b_n++; b_wcnt = wr_cnt; end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_write(input logic [15:0] a, input logic [1:0] l, input logic [2:0] s,
                            input logic inc, input logic bf, input logic pe, input logic [31:0] d);
    @(negedge clk_i);
    aw_addr_i = a; aw_len_i = l; aw_size_i = s; aw_incr_i = inc;
    aw_bufable_i = bf; aw_periph_i = pe; aw_valid_i = 1'b1;
    while (!aw_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1 aw_valid_i = 1'b0;
    for (int k = 0; k <= int'(l); k++) begin
      @(negedge clk_i);
      w_valid_i = 1'b1; w_data_i = d + 32'(k); w_last_i = (k == int'(l));
      while (!w_ready_o) @(negedge clk_i);
      @(posedge clk_i); #1 w_valid_i = 1'b0; w_last_i = 1'b0;
    end
  endtask

  task automatic send_read(input logic [15:0] a, input logic [1:0] l, input logic [2:0] s,
                           input logic inc, input logic pe);
    @(negedge clk_i);
    ar_addr_i = a; ar_len_i = l; ar_size_i = s; ar_incr_i = inc; ar_periph_i = pe;
    ar_valid_i = 1'b1;
    while (!ar_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1 ar_valid_i = 1'b0;
  endtask

  task automatic wait_r(input int target);
    for (int k = 0; k < 200 && r_n < target; k++) @(negedge clk_i);
  endtask

  typedef struct packed {
    logic [15:0] wa; logic [1:0] wl; logic [2:0] ws; logic wi;
    logic [15:0] ra; logic [1:0] rl; logic [2:0] rs; logic ri;
    logic        hit;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h0100, 2'd1, 3'd2, 1'b1, 16'h0104, 2'd0, 3'd2, 1'b1, 1'b1},
    '{16'h0100, 2'd1, 3'd2, 1'b1, 16'h0108, 2'd0, 3'd2, 1'b1, 1'b0},
    '{16'h0100, 2'd1, 3'd2, 1'b0, 16'h0104, 2'd0, 3'd2, 1'b1, 1'b0},
    '{16'h0100, 2'd1, 3'd2, 1'b0, 16'h0103, 2'd0, 3'd0, 1'b1, 1'b1},
    '{16'h0200, 2'd3, 3'd1, 1'b1, 16'h01F8, 2'd1, 3'd2, 1'b1, 1'b0},
    '{16'h0200, 2'd3, 3'd1, 1'b1, 16'h01FC, 2'd1, 3'd2, 1'b1, 1'b1},
    '{16'h0300, 2'd1, 3'd0, 1'b1, 16'h02F0, 2'd3, 3'd2, 1'b1, 1'b0},
    '{16'h0300, 2'd1, 3'd0, 1'b1, 16'h02F0, 2'd3, 3'd3, 1'b1, 1'b1}
  };

  initial begin
    int w0, rd0, rn0, bn0, seen;
    logic [31:0] d1;

    cycles(3);
    // R10 reset state
    chk(aw_ready_o == 1'b1, "R10 aw_ready", 32'(aw_ready_o), 1);
    chk(ar_ready_o == 1'b1, "R10 ar_ready", 32'(ar_ready_o), 1);
    chk(b_valid_o == 1'b0, "R10 b_valid", 32'(b_valid_o), 0);
    chk(r_valid_o == 1'b0, "R10 r_valid", 32'(r_valid_o), 0);
    chk(mem_req_o == 1'b0, "R10 mem_req", 32'(mem_req_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cycles(2);

    // R4/R3/R5 overlap table: write beats done before first read beat
    foreach (VECS[i]) begin
      frozen = 1'b1;
      w0 = wr_cnt; rd0 = rd_cnt; rn0 = r_n;
      send_write(VECS[i].wa, VECS[i].wl, VECS[i].ws, VECS[i].wi, 1'b1, 1'b0, 32'h1000 * (i + 1));
      send_read(VECS[i].ra, VECS[i].rl, VECS[i].rs, VECS[i].ri, 1'b0);
      cycles(5);
      frozen = 1'b0;
      wait_r(rn0 + int'(VECS[i].rl) + 1);
      cycles(12);
      seen = rd_wlog[rd0] - w0;
      if (VECS[i].hit)
        chk(seen == int'(VECS[i].wl) + 1, "R4 R3 overlap drains first", 32'(seen), 32'(VECS[i].wl) + 1);
      else
        chk(seen == 1, "R4 R5 no overlap bypasses", 32'(seen), 1);
    end

    // R1 early response, then R3 new data
    send_write(16'h0400, 2'd0, 3'd2, 1'b1, 1'b1, 1'b0, 32'hDEAD0000);
    cycles(10);
    frozen = 1'b1;
    w0 = wr_cnt; bn0 = b_n; rd0 = rd_cnt; rn0 = r_n;
    send_write(16'h0400, 2'd0, 3'd2, 1'b1, 1'b1, 1'b0, 32'hAAAA1111);
    cycles(3);
    chk(b_n == bn0 + 1, "R1 response before memory", 32'(b_n - bn0), 1);
    chk(wr_cnt == w0, "R1 no memory write yet", 32'(wr_cnt - w0), 0);
    send_read(16'h0400, 2'd0, 3'd2, 1'b1, 1'b0);
    cycles(5);
    frozen = 1'b0;
    wait_r(rn0 + 1);
    chk(rbuf[rn0] == 32'hAAAA1111, "R3 read returns new data", rbuf[rn0], 32'hAAAA1111);
    chk(rd_wlog[rd0] - w0 == 1, "R3 read after drain", 32'(rd_wlog[rd0] - w0), 1);
    cycles(10);

    // R2 non-bufferable write
    frozen = 1'b1;
    w0 = wr_cnt; bn0 = b_n;
    send_write(16'h0500, 2'd1, 3'd2, 1'b1, 1'b0, 1'b0, 32'h5000);
    cycles(10);
    chk(b_n == bn0, "R2 no response while memory stalled", 32'(b_n - bn0), 0);
    frozen = 1'b0;
    cycles(15);
    chk(b_n == bn0 + 1, "R2 response after completion", 32'(b_n - bn0), 1);
    chk(b_wcnt - w0 == 2, "R2 both beats done before response", 32'(b_wcnt - w0), 2);

    // R2 peripheral write ignores bufferable bit
    frozen = 1'b1;
    bn0 = b_n;
    send_write(16'h0540, 2'd0, 3'd2, 1'b1, 1'b1, 1'b1, 32'h5400);
    cycles(10);
    chk(b_n == bn0, "R2 peripheral write held", 32'(b_n - bn0), 0);
    frozen = 1'b0;
    cycles(10);
    chk(b_n == bn0 + 1, "R2 peripheral write answered", 32'(b_n - bn0), 1);

    // R6 peripheral read waits for disjoint writes
    frozen = 1'b1;
    w0 = wr_cnt; rd0 = rd_cnt; rn0 = r_n;
    send_write(16'h0600, 2'd1, 3'd2, 1'b1, 1'b1, 1'b0, 32'h6000);
    send_read(16'h0900, 2'd0, 3'd2, 1'b1, 1'b1);
    cycles(5);
    frozen = 1'b0;
    wait_r(rn0 + 1);
    chk(rd_wlog[rd0] - w0 == 2, "R6 peripheral read ordered", 32'(rd_wlog[rd0] - w0), 2);
    cycles(10);

    // R8 full queue, R7 arrival order
    frozen = 1'b1;
    w0 = wr_cnt;
    for (int k = 0; k < 4; k++)
      send_write(16'h0A00 + 16'(k * 16), 2'd0, 3'd2, 1'b1, 1'b1, 1'b0, 32'hA000 + 32'(k));
    cycles(4);
    chk(aw_ready_o == 1'b0, "R8 aw_ready low when full", 32'(aw_ready_o), 0);
    frozen = 1'b0;
    cycles(20);
    chk(aw_ready_o == 1'b1, "R8 aw_ready back after drain", 32'(aw_ready_o), 1);
    for (int k = 0; k < 4; k++)
      chk(wr_log[w0 + k] == 32'h0A00 + 32'(k * 16), "R7 arrival order", 32'(wr_log[w0 + k]), 32'h0A00 + 32'(k * 16));

    // R7 beat addresses INCR and FIXED
    frozen = 1'b1;
    w0 = wr_cnt;
    send_write(16'h0700, 2'd2, 3'd2, 1'b1, 1'b1, 1'b0, 32'h7000);
    send_write(16'h0800, 2'd1, 3'd2, 1'b0, 1'b1, 1'b0, 32'h8000);
    frozen = 1'b0;
    cycles(25);
    chk(wr_log[w0]     == 32'h0700, "R7 incr beat0", 32'(wr_log[w0]), 32'h0700);
    chk(wr_log[w0 + 1] == 32'h0704, "R7 incr beat1", 32'(wr_log[w0 + 1]), 32'h0704);
    chk(wr_log[w0 + 2] == 32'h0708, "R7 incr beat2", 32'(wr_log[w0 + 2]), 32'h0708);
    chk(wr_log[w0 + 3] == 32'h0800, "R7 fixed beat0", 32'(wr_log[w0 + 3]), 32'h0800);
    chk(wr_log[w0 + 4] == 32'h0800, "R7 fixed beat1", 32'(wr_log[w0 + 4]), 32'h0800);
    chk(mem_m[32'h0800] == 32'h8001, "R7 fixed last data wins", mem_m[32'h0800], 32'h8001);

    // R9 response hold and code
    b_ready_i = 1'b0;
    send_write(16'h0B00, 2'd0, 3'd2, 1'b1, 1'b1, 1'b0, 32'hB0B0);
    cycles(4);
    chk(b_valid_o == 1'b1, "R9 b_valid held", 32'(b_valid_o), 1);
    chk(b_resp_o == 2'b00, "R9 OKAY response", 32'(b_resp_o), 0);
    b_ready_i = 1'b1;
    cycles(10);

    // R9 read data hold
    r_ready_i = 1'b0;
    send_read(16'h0B00, 2'd0, 3'd2, 1'b1, 1'b0);
    cycles(6);
    d1 = r_data_o;
    cycles(3);
    chk(r_valid_o == 1'b1, "R9 r_valid held", 32'(r_valid_o), 1);
    chk(r_data_o == d1 && d1 == 32'hB0B0, "R9 r_data stable", r_data_o, 32'hB0B0);
    r_ready_i = 1'b1;
    cycles(4);
    chk(r_valid_o == 1'b0, "R9 r_valid drops after accept", 32'(r_valid_o), 0);

    summary();
    $finish;
  end
endmodule